// File: doc/BRIEF.md
# Configuration Address/Data Window Decoder

This block is the target side of the indirect configuration access scheme that uses an address port and a data window on a small I/O port bus. Software first writes a 32-bit selector to the address port at 0xCF8. The selector holds an enable flag, a bus number, a device/function number and a dword register index. Software then reads or writes the four data ports at 0xCFC to 0xCFF. The decoder turns each data-port access into a configuration request. The request carries the selected bus, device/function and register, byte enables taken from the port offset and the access size, and write data shifted onto the matching lanes. On a read, the decoder takes the completion data from those lanes and returns it right-justified.

The I/O bus presents a byte address, a size code (0 = byte, 1 = word, 2 = dword), a write strobe, a read strobe and right-justified write data. Read data comes back one cycle after the read strobe, together with a valid flag. Only a full dword write at the address port changes the selector. Narrow accesses to the other three address-window ports leave the selector alone. A small register-file stub stands in for the configuration targets. On bus 0, devices/functions 0 to N_DEV-1 exist, and each has N_REG dword registers. Register 0 of each device is a read-only identity word.

Top module: `cfg_window_decoder`

## Requirements
- R1: After reset the selector reads back as 0. A dword write at 0xCF8 latches bit 31 (enable), bits 23:16 (bus), bits 15:8 (device/function) and bits 7:2 (register). Bits 30:24 and 1:0 read back as zero, so 0x80000000 reads back as 0x80000000 and 0xFFFFFFFF reads back as 0x80FFFFFC.
- R2: Any access to 0xCF8 to 0xCFB other than a dword at 0xCF8 leaves the selector unchanged. Such reads return all ones within the access width: 0xFF for a byte, 0xFFFF for a word.
- R3: Reading the selector and writing the same value back restores the state exactly, including the target that later data-port accesses reach.
- R4: A data-port access with offset o = address[1:0] sends byte enables 0001b shifted left by o for a byte, 0011b shifted left by o for a word (o must be 0 or 2), and 1111b for a dword (o must be 0). A misaligned word or dword access is not forwarded: writes are dropped and reads return all ones within the width.
- R5: A forwarded write updates only the enabled byte lanes of the selected register. Write data byte k lands on lane o+k.
- R6: A forwarded read returns the completion lanes starting at lane o, right-justified, with the bits above the access width set to zero.
- R7: While the enable bit is clear, data-port reads return all ones within the width and data-port writes are dropped.
- R8: A request to a bus other than 0, or to a device/function at or above N_DEV, reads as 0xFFFFFFFF (masked to the width) and writes to it change nothing.
- R9: In the stub, register 0 of device d reads {DEV_ID_BASE + d, VENDOR_ID} (upper half, lower half) and ignores writes. Registers 1 to N_REG-1 reset to zero and can be written. Register indices at or above N_REG read as zero.
- R10: io_rvalid is high in exactly the cycle after io_rd was sampled, and io_rdata is valid in that cycle. Reads outside the eight-port window return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O byte address |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 32 | Right-justified write data |
| io_rdata | output | 32 | Right-justified read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read response valid, one cycle after io_rd |

## Verification
The assertions assume that io_rd and io_wr are never high in the same cycle and that io_size never carries the unused code 3. Under these assumptions, each sampled strobe is exactly one access, and the byte-enable and response-timing properties can be stated without exceptions. The bench issues every access through one task per direction. Each task raises a single strobe for one cycle with a size from 0 to 2 and then drops it, so the stimulus never leaves that envelope. The stimulus sweeps device/function and register indices across the existing, missing and out-of-range cases, and covers every lane offset for each legal size.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_ADDR = 2'd1,
        RG_DATA = 2'd2
    } region_e;

    // Selector as held in flops: only the architected fields are stored
    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [7:0] devfn;
        logic [5:0] dw;
    } cfg_addr_t;

    typedef struct packed {
        logic        valid;
        logic        write;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [5:0]  dw;
        logic [3:0]  be;
        logic [31:0] wdata;
    } cfg_req_t;

    function automatic logic [3:0] size_lanes(acc_size_e sz);
        case (sz)
            SZ_BYTE:  return 4'b0001;
            SZ_WORD:  return 4'b0011;
            SZ_DWORD: return 4'b1111;
            default:  return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] size_ones(acc_size_e sz);
        case (sz)
            SZ_BYTE:  return 32'h0000_00FF;
            SZ_WORD:  return 32'h0000_FFFF;
            SZ_DWORD: return 32'hFFFF_FFFF;
            default:  return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic is_aligned(acc_size_e sz, logic [1:0] off);
        case (sz)
            SZ_BYTE:  return 1'b1;
            SZ_WORD:  return ~off[0];
            SZ_DWORD: return (off == 2'd0);
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] addr_pack(cfg_addr_t a);
        return {a.en, 7'b0, a.bus, a.devfn, a.dw, 2'b00};
    endfunction

    function automatic cfg_addr_t addr_unpack(logic [31:0] w);
        cfg_addr_t a;
        a.en    = w[31];
        a.bus   = w[23:16];
        a.devfn = w[15:8];
        a.dw    = w[7:2];
        return a;
    endfunction

endpackage

// File: rtl/cfgwin_port_decode.sv
module cfgwin_port_decode
    import cfgwin_pkg::*;
#(
    parameter int             IO_AW     = 16,
    parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic [IO_AW-1:0] io_addr,
    output region_e          region,
    output logic [1:0]       offset
);

    logic [IO_AW-1:0] dword_base;

    always_comb begin
        offset     = io_addr[1:0];
        dword_base = {io_addr[IO_AW-1:2], 2'b00};
        if (dword_base == ADDR_PORT)
            region = RG_ADDR;
        else if (dword_base == DATA_PORT)
            region = RG_DATA;
        else
            region = RG_NONE;
    end

endmodule

// File: rtl/cfgwin_addr_reg.sv
module cfgwin_addr_reg
    import cfgwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  logic [31:0] wdata,
    output cfg_addr_t   addr_q
);

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (wr_hit)
            addr_q <= addr_unpack(wdata);
    end

    // R1: a full-dword write at the address port latches the architected fields
    p_latch_fields_r1: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (addr_pack(addr_q) == ($past(wdata) & 32'h80FF_FFFC)));

    // R2: nothing else moves the selector
    p_hold_selector_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(addr_q));

endmodule

// File: rtl/cfgwin_data_xlate.sv
module cfgwin_data_xlate
    import cfgwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_window,
    input  logic        rd,
    input  logic        wr,
    input  logic [1:0]  offset,
    input  acc_size_e   size,
    input  logic [31:0] wdata,
    input  cfg_addr_t   sel,
    input  logic [31:0] cpl_data,
    output cfg_req_t    req,
    output logic [31:0] rd_data
);

    logic        ok;
    logic [4:0]  sh;
    logic [31:0] ones;

    always_comb begin
        ok   = sel.en & is_aligned(size, offset);
        sh   = {offset, 3'b000};
        ones = size_ones(size);

        req.valid = in_window & (rd | wr) & ok;
        req.write = wr;
        req.bus   = sel.bus;
        req.devfn = sel.devfn;
        req.dw    = sel.dw;
        req.be    = size_lanes(size) << offset;
        req.wdata = wdata << sh;

        if (ok)
            rd_data = (cpl_data >> sh) & ones;
        else
            rd_data = ones;
    end

    // R7: a cleared enable never produces a request
    p_no_req_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        !sel.en |-> !req.valid);

    // R4: forwarded byte enables cover one, two or four contiguous lanes
    p_be_shape_r4: assert property (@(posedge clk) disable iff (rst)
        req.valid |-> (req.be == 4'b0001 || req.be == 4'b0010 || req.be == 4'b0100 ||
                       req.be == 4'b1000 || req.be == 4'b0011 || req.be == 4'b1100 ||
                       req.be == 4'b1111));

endmodule

// File: rtl/cfgwin_target_stub.sv
module cfgwin_target_stub
    import cfgwin_pkg::*;
#(
    parameter int          N_DEV       = 4,
    parameter int          N_REG       = 16,
    parameter logic [15:0] VENDOR_ID   = 16'h1D5A,
    parameter logic [15:0] DEV_ID_BASE = 16'h7C00
) (
    input  logic        clk,
    input  logic        rst,
    input  cfg_req_t    req,
    output logic [31:0] cpl_data
);

    logic [31:0] regs_q  [N_DEV][N_REG];
    logic [31:0] id_word [N_DEV];
    logic        dev_hit;
    logic        reg_hit;

    for (genvar gd = 0; gd < N_DEV; gd++) begin : g_id
        assign id_word[gd] = {DEV_ID_BASE + 16'(gd), VENDOR_ID};
    end

    assign dev_hit = (req.bus == 8'd0) && ({1'b0, req.devfn} < 9'(N_DEV));
    assign reg_hit = ({1'b0, req.dw} < 7'(N_REG));

    always_comb begin
        if (!dev_hit) begin
            cpl_data = 32'hFFFF_FFFF;
        end else begin
            cpl_data = 32'h0;
            if (reg_hit) begin
                for (int d = 0; d < N_DEV; d++) begin
                    for (int r = 0; r < N_REG; r++) begin
                        if (req.devfn == d[7:0] && req.dw == r[5:0])
                            cpl_data = (r == 0) ? id_word[d] : regs_q[d][r];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < N_DEV; d++)
                for (int r = 0; r < N_REG; r++)
                    regs_q[d][r] <= '0;
        end else if (req.valid && req.write && dev_hit && reg_hit) begin
            for (int d = 0; d < N_DEV; d++) begin
                for (int r = 1; r < N_REG; r++) begin
                    if (req.devfn == d[7:0] && req.dw == r[5:0]) begin
                        for (int b = 0; b < 4; b++)
                            if (req.be[b])
                                regs_q[d][r][b*8 +: 8] <= req.wdata[b*8 +: 8];
                    end
                end
            end
        end
    end

    // R8: a missing device completes reads with all ones
    p_nodev_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !req.write && !dev_hit) |-> (cpl_data == 32'hFFFF_FFFF));

    // R9: register 0 of a present device always carries the vendor half
    p_id_vendor_r9: assert property (@(posedge clk) disable iff (rst)
        (req.valid && dev_hit && req.dw == 6'd0) |-> (cpl_data[15:0] == VENDOR_ID));

endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
    import cfgwin_pkg::*;
#(
    parameter int          N_DEV       = 4,
    parameter int          N_REG       = 16,
    parameter logic [15:0] ADDR_PORT   = 16'h0CF8,
    parameter logic [15:0] DATA_PORT   = 16'h0CFC,
    parameter logic [15:0] VENDOR_ID   = 16'h1D5A,
    parameter logic [15:0] DEV_ID_BASE = 16'h7C00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic [1:0]  io_size,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        io_rvalid
);

    region_e     region;
    logic [1:0]  offset;
    acc_size_e   size;
    logic        sel_wr_hit;
    cfg_addr_t   sel_q;
    cfg_req_t    req;
    logic [31:0] cpl_data;
    logic [31:0] win_rd_data;
    logic [31:0] rd_mux;

    assign size = acc_size_e'(io_size);

    cfgwin_port_decode #(
        .IO_AW     (16),
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_decode (
        .io_addr (io_addr),
        .region  (region),
        .offset  (offset)
    );

    assign sel_wr_hit = io_wr && (region == RG_ADDR) && (offset == 2'd0) && (size == SZ_DWORD);

    cfgwin_addr_reg u_sel (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (sel_wr_hit),
        .wdata  (io_wdata),
        .addr_q (sel_q)
    );

    cfgwin_data_xlate u_xlate (
        .clk       (clk),
        .rst       (rst),
        .in_window (region == RG_DATA),
        .rd        (io_rd),
        .wr        (io_wr),
        .offset    (offset),
        .size      (size),
        .wdata     (io_wdata),
        .sel       (sel_q),
        .cpl_data  (cpl_data),
        .req       (req),
        .rd_data   (win_rd_data)
    );

    cfgwin_target_stub #(
        .N_DEV       (N_DEV),
        .N_REG       (N_REG),
        .VENDOR_ID   (VENDOR_ID),
        .DEV_ID_BASE (DEV_ID_BASE)
    ) u_stub (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cpl_data (cpl_data)
    );

    always_comb begin
        case (region)
            RG_ADDR: rd_mux = (size == SZ_DWORD && offset == 2'd0) ? addr_pack(sel_q)
                                                                  : size_ones(size);
            RG_DATA: rd_mux = win_rd_data;
            default: rd_mux = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_rdata  <= '0;
            io_rvalid <= 1'b0;
        end else begin
            io_rvalid <= io_rd;
            if (io_rd)
                io_rdata <= rd_mux;
        end
    end

    // R10: one response cycle per read strobe, none otherwise
    p_rvalid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        io_rd |=> io_rvalid);
    p_rvalid_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> !io_rvalid);

    // R2: a non-dword read of the address window answers with ones in width
    p_addr_narrow_ones_r2: assert property (@(posedge clk) disable iff (rst)
        (io_rd && region == RG_ADDR && size == SZ_BYTE) |=> (io_rdata == 32'h0000_00FF));

endmodule

// File: tb/cfg_window_decoder_bench.sv
module cfg_window_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_rvalid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cfg_window_decoder u_cfg_window_decoder (
        .clk       (clk),
        .rst       (rst),
        .io_addr   (io_addr),
        .io_size   (io_size),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .io_rvalid (io_rvalid)
    );

    // bench model of the selector and target contents
    bit          m_en;
    int          m_bus, m_dev, m_reg;
    logic [31:0] exp_mem [4][16];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
        io_addr = a; io_size = sz; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, input logic [1:0] sz,
                         output logic [31:0] d, output logic v);
        io_addr = a; io_size = sz; io_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        d = io_rdata; v = io_rvalid;
        io_rd = 1'b0;
    endtask

    function automatic logic [31:0] mask_of(int sz);
        return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic bit fits(int off, int sz);
        return (sz == 0) || (sz == 1 && off % 2 == 0) || (sz == 2 && off == 0);
    endfunction

    function automatic logic [31:0] dword_model();
        if (m_bus != 0 || m_dev >= 4) return 32'hFFFF_FFFF;
        if (m_reg == 0) return {16'h7C00 + 16'(m_dev), 16'h1D5A};
        if (m_reg >= 16) return 32'h0;
        return exp_mem[m_dev][m_reg];
    endfunction

    function automatic logic [31:0] read_model(int off, int sz);
        if (!m_en || !fits(off, sz)) return mask_of(sz);
        return (dword_model() >> (8 * off)) & mask_of(sz);
    endfunction

    task automatic set_sel(input bit en, input int bus, input int dev, input int rg);
        do_wr(16'h0CF8, 2'd2, {en, 7'h55, 8'(bus), 8'(dev), 6'(rg), 2'b11});
        m_en = en; m_bus = bus; m_dev = dev; m_reg = rg;
    endtask

    task automatic cfg_wr(input int off, input int sz, input logic [31:0] d);
        int nb;
        do_wr(16'h0CFC + 16'(off), 2'(sz), d);
        nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        if (m_en && fits(off, sz) && m_bus == 0 && m_dev < 4 && m_reg >= 1 && m_reg < 16)
            for (int b = 0; b < nb; b++)
                exp_mem[m_dev][m_reg][8*(off+b) +: 8] = d[8*b +: 8];
    endtask

    task automatic cfg_chk(input string tag, input int off, input int sz);
        logic [31:0] d; logic v;
        do_rd(16'h0CFC + 16'(off), 2'(sz), d, v);
        check(tag, d, read_model(off, sz));
    endtask

    initial begin
        logic [31:0] d, saved;
        logic v;
        string tag;
        for (int i = 0; i < 4; i++) for (int j = 0; j < 16; j++) exp_mem[i][j] = '0;
        m_en = 0; m_bus = 0; m_dev = 0; m_reg = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: no response before any read
        check("R10 rvalid idle after reset", {31'b0, io_rvalid}, 32'h0);
        // R1: reset value of the selector
        do_rd(16'h0CF8, 2'd2, d, v);
        check("R1 selector reset", d, 32'h0);
        check("R10 rvalid after read", {31'b0, v}, 32'h1);
        @(negedge clk);
        check("R10 rvalid drops", {31'b0, io_rvalid}, 32'h0);

        do_wr(16'h0CF8, 2'd2, 32'h8000_0000);
        do_rd(16'h0CF8, 2'd2, d, v);
        check("R1 enable-only readback", d, 32'h8000_0000);
        do_wr(16'h0CF8, 2'd2, 32'hFFFF_FFFF);
        do_rd(16'h0CF8, 2'd2, d, v);
        check("R1 reserved bits zero", d, 32'h80FF_FFFC);

        // R5 R6 R8 R9: sweep device/function and register indices
        for (int dev = 0; dev < 6; dev++) begin
            for (int rg = 0; rg < 18; rg++) begin
                tag = (dev >= 4) ? "R8" : (rg == 0 || rg >= 16) ? "R9" : "R5";
                set_sel(1, 0, dev, rg);
                cfg_wr(0, 2, {8'(dev), 8'(rg), ~8'(dev), 8'h5A ^ 8'(rg)});
                cfg_chk({tag, " dword readback"}, 0, 2);
                for (int o = 0; o < 4; o++)
                    cfg_wr(o, 0, 32'hC0 + 32'(o * 16) + 32'(dev));
                for (int o = 0; o < 4; o += 2)
                    cfg_chk((dev >= 4) ? "R8 word lane read" : "R6 word lane read", o, 1);
                for (int o = 0; o < 4; o++)
                    cfg_chk((dev >= 4) ? "R8 byte lane read" : "R6 byte lane read", o, 0);
            end
        end

        // R8: a non-zero bus reads as missing
        set_sel(1, 1, 0, 1);
        cfg_wr(0, 2, 32'h1234_5678);
        cfg_chk("R8 other bus dword", 0, 2);
        cfg_chk("R8 other bus byte", 3, 0);
        set_sel(1, 0, 0, 1);
        cfg_chk("R8 write to other bus dropped", 0, 2);

        // R4: byte enables from offset and size; misaligned accesses dropped
        set_sel(1, 0, 1, 2);
        cfg_wr(0, 2, 32'h1111_2222);
        cfg_wr(2, 1, 32'h0000_BEEF);
        cfg_chk("R4 word at offset 2 enables upper lanes", 0, 2);
        check("R4 model upper half", exp_mem[1][2], 32'hBEEF_2222);
        cfg_wr(1, 1, 32'h0000_DEAD);
        cfg_wr(2, 2, 32'hCAFE_F00D);
        cfg_chk("R4 misaligned writes dropped", 0, 2);
        cfg_chk("R4 misaligned word read", 1, 1);
        cfg_chk("R4 misaligned dword read", 2, 2);

        // R7: enable clear blocks the data window
        set_sel(0, 0, 1, 3);
        cfg_wr(0, 2, 32'hA5A5_A5A5);
        cfg_chk("R7 disabled dword read", 0, 2);
        cfg_chk("R7 disabled word read", 2, 1);
        cfg_chk("R7 disabled byte read", 1, 0);
        set_sel(1, 0, 1, 3);
        cfg_chk("R7 disabled write dropped", 0, 2);

        // R2: narrow accesses at the address window do not move the selector
        set_sel(1, 0, 2, 5);
        cfg_wr(0, 2, 32'h0BAD_F00D);
        do_wr(16'h0CFB, 2'd0, 32'h01);
        do_wr(16'h0CF8, 2'd0, 32'h00);
        do_wr(16'h0CF9, 2'd0, 32'h33);
        do_wr(16'h0CFA, 2'd1, 32'h0000);
        do_wr(16'h0CF8, 2'd1, 32'h0000);
        do_rd(16'h0CF8, 2'd2, d, v);
        check("R2 selector kept", d, 32'h8000_0214);
        do_rd(16'h0CFB, 2'd0, d, v);
        check("R2 byte read of address window", d, 32'hFF);
        do_rd(16'h0CFA, 2'd1, d, v);
        check("R2 word read of address window", d, 32'hFFFF);
        cfg_chk("R2 data still reaches kept target", 0, 2);

        // R3: save and restore the selector
        do_rd(16'h0CF8, 2'd2, saved, v);
        set_sel(1, 0, 3, 7);
        cfg_wr(0, 2, 32'h7777_0003);
        do_wr(16'h0CF8, 2'd2, saved);
        m_en = 1; m_bus = 0; m_dev = 2; m_reg = 5;
        do_rd(16'h0CF8, 2'd2, d, v);
        check("R3 restored selector", d, saved);
        cfg_chk("R3 restored target", 0, 2);

        // R10: outside the window reads zero
        do_rd(16'h0080, 2'd2, d, v);
        check("R10 outside window", d, 32'h0);
        check("R10 outside window valid", {31'b0, v}, 32'h1);
        do_rd(16'h0D00, 2'd0, d, v);
        check("R10 outside window byte", d, 32'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule